// File: doc/BRIEF.md
# Nibble-Serialized Command Register Port

This block is the command side of a master-driven byte bus. One dedicated value of the 3-bit bus address routes strobes to the block. Every other address belongs to the data endpoints, and the block ignores those transfers. Through this port the master reaches an internal file of 64 byte-wide registers.

Every access opens with an address command. This byte names a register offset and says whether the access is a read or a write.

- A write follows the address command with two data commands. The first carries the upper nibble and the second carries the lower nibble. The target register changes only when the lower nibble arrives.
- A read returns the whole register byte on the next read strobe.

While an operation is pending, the block drops its ready output.

The block also gathers status events into an interrupt status byte. An enable byte gates which events are recorded. The active-low interrupt output is asserted while any enabled status bit is set. Reading the status byte clears the bits it returned.

Top module: `cmdport`

## Requirements
- R1: Strobes are decoded only when `fifo_addr` equals the command select value (default 3'd4). A strobe at any other address changes neither `ready`, `rdata` nor any register.
- R2: A write strobe with `wdata[7]`=1 is an address command. In it, `wdata[6]`=1 requests a read and `wdata[5:0]` is the register offset. `ready` is low from the cycle after it until the operation completes.
- R3: After a write address command, two data commands (`wdata[7]`=0) carry the upper nibble and then the lower nibble in `wdata[3:0]`. The register takes `{upper, lower}` only on the second one, and `ready` returns high the cycle after.
- R4: An address command that arrives before the lower nibble aborts the pending write. The target register keeps its old value.
- R5: After a read address command, the next read strobe loads the full register byte into `rdata`. The new value is visible from the cycle after the strobe and is held until the next completed read. Read strobes and data commands with no operation pending are ignored.
- R6: After reset, these values hold:
  - offset 0x01 reads 0xC0;
  - the enable byte at offset 0x2E reads 0xFF;
  - the status byte at offset 0x2F reads 0x00;
  - every other offset reads 0x00;
  - `ready`=1 and `int_n`=1.
- R7: A pulse on `evt_i[i]` sets status bit i only if enable bit i is set. Bit 6 is the endpoint-0 buffer-available event.
- R8: `int_n` is low exactly when some status bit is set whose enable bit is also set. Clearing an enable bit releases `int_n` without clearing status.
- R9: Reading the status byte clears the bits it returned. An event that arrives in the same cycle as the read stays set.
- R10: Writes to the status byte offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_addr | input | 3 | Bus address; one value selects this port |
| wr_strobe | input | 1 | Write strobe, one cycle per transfer |
| rd_strobe | input | 1 | Read strobe, one cycle per transfer |
| wdata | input | 8 | Command or data byte from the master |
| evt_i | input | 8 | Status event pulses, one per status bit |
| rdata | output | 8 | Byte returned by the last completed read |
| ready | output | 1 | High when no command is pending |
| int_n | output | 1 | Active-low interrupt |

## Verification
The bench uses the default parameters: command select 4, six offset bits, and status and enable bytes at 0x2F and 0x2E. With these values the whole 64-entry map can be reached, including the top offset 0x3F and the protected status offset. A behavioural model advances alongside the design and compares `ready`, `int_n` and `rdata` every cycle. This covers aborted writes, stray strobes, foreign-address strobes, and an event that collides with a status read.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;

    typedef enum logic [1:0] {
        CP_IDLE = 2'd0,
        CP_HI   = 2'd1,
        CP_LO   = 2'd2,
        CP_RD   = 2'd3
    } cp_state_e;

endpackage

// File: rtl/cmdport_decode.sv
module cmdport_decode #(
    parameter logic [2:0] CMD_SEL = 3'd4
) (
    input  logic [2:0] fifo_addr,
    input  logic       wr_strobe,
    input  logic       rd_strobe,
    input  logic       mark_bit,
    output logic       addr_cmd,
    output logic       data_cmd,
    output logic       rd_req
);
    logic hit;

    always_comb begin
        hit      = (fifo_addr == CMD_SEL);
        addr_cmd = hit && wr_strobe && mark_bit;
        data_cmd = hit && wr_strobe && !mark_bit;
        // a simultaneous write strobe takes precedence
        rd_req   = hit && rd_strobe && !wr_strobe;
    end
endmodule

// File: rtl/cmdport_seq.sv
module cmdport_seq
    import cmdport_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_cmd,
    input  logic          data_cmd,
    input  logic          rd_req,
    input  logic [7:0]    wdata,
    output logic          wr_en,
    output logic [AW-1:0] ofs,
    output logic [7:0]    wr_val,
    output logic          rd_fire,
    output logic          ready
);
    typedef struct packed {
        cp_state_e     st;
        logic [AW-1:0] ofs;
        logic [3:0]    hi;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        wr_en   = 1'b0;
        rd_fire = 1'b0;
        wr_val  = {s_q.hi, wdata[3:0]};
        if (addr_cmd) begin
            // a new address always restarts, dropping any partial write
            s_d.ofs = wdata[AW-1:0];
            s_d.st  = wdata[6] ? CP_RD : CP_HI;
        end else if (data_cmd) begin
            case (s_q.st)
                CP_HI: begin
                    s_d.hi = wdata[3:0];
                    s_d.st = CP_LO;
                end
                CP_LO: begin
                    wr_en  = 1'b1;
                    s_d.st = CP_IDLE;
                end
                default: ;
            endcase
        end else if (rd_req && s_q.st == CP_RD) begin
            rd_fire = 1'b1;
            s_d.st  = CP_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: CP_IDLE, ofs: '0, hi: '0};
        else        s_q <= s_d;
    end

    assign ofs   = s_q.ofs;
    assign ready = (s_q.st == CP_IDLE);

    // R2
    addr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_cmd |=> !ready);
    // R3
    lo_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ready);
    // R4
    hi_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == CP_HI) |-> !wr_en);
endmodule

// File: rtl/cmdport_regs.sv
module cmdport_regs #(
    parameter int             AW       = 6,
    parameter logic [AW-1:0]  CFG_OFS  = 6'h01,
    parameter logic [7:0]     CFG_RST  = 8'hC0,
    parameter logic [AW-1:0]  EN_OFS   = 6'h2E,
    parameter logic [AW-1:0]  STAT_OFS = 6'h2F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_ofs,
    input  logic [7:0]    wr_val,
    input  logic [AW-1:0] rd_ofs,
    output logic [7:0]    rd_data
);
    localparam int NREG = 1 << AW;

    logic [NREG-1:0][7:0] mem_d, mem_q;
    logic [NREG-1:0][7:0] mem_rst;

    for (genvar k = 0; k < NREG; k++) begin : g_ent
        if (k == int'(EN_OFS) || k == int'(STAT_OFS)) begin : g_hole
            // these offsets live in the interrupt unit
            assign mem_d[k]   = '0;
            assign mem_rst[k] = '0;
        end else begin : g_cell
            assign mem_rst[k] = (k == int'(CFG_OFS)) ? CFG_RST : 8'h00;
            always_comb begin
                mem_d[k] = mem_q[k];
                if (wr_en && wr_ofs == AW'(k)) mem_d[k] = wr_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= mem_rst;
        else        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_ofs];

    // R4
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem_q));
endmodule

// File: rtl/cmdport_irq.sv
module cmdport_irq #(
    parameter int NEVT = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEVT-1:0] evt_i,
    input  logic            en_wr,
    input  logic [NEVT-1:0] en_val,
    input  logic [NEVT-1:0] stat_clr,
    output logic [NEVT-1:0] en_q,
    output logic [NEVT-1:0] stat_q,
    output logic            int_n
);
    typedef struct packed {
        logic [NEVT-1:0] en;
        logic [NEVT-1:0] stat;
    } irq_t;

    irq_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.stat = (r_q.stat & ~stat_clr) | (evt_i & r_q.en);
        if (en_wr) r_d.en = en_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{en: '1, stat: '0};
        else        r_q <= r_d;
    end

    assign en_q   = r_q.en;
    assign stat_q = r_q.stat;
    assign int_n  = ~|(r_q.stat & r_q.en);

    // R9
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
    // R7
    stat_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));
endmodule

// File: rtl/cmdport.sv
module cmdport
    import cmdport_pkg::*;
#(
    parameter logic [2:0] CMD_SEL  = 3'd4,
    parameter int         AW       = 6,
    parameter logic [5:0] CFG_OFS  = 6'h01,
    parameter logic [7:0] CFG_RST  = 8'hC0,
    parameter logic [5:0] EN_OFS   = 6'h2E,
    parameter logic [5:0] STAT_OFS = 6'h2F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] fifo_addr,
    input  logic       wr_strobe,
    input  logic       rd_strobe,
    input  logic [7:0] wdata,
    input  logic [7:0] evt_i,
    output logic [7:0] rdata,
    output logic       ready,
    output logic       int_n
);
    localparam int NEVT = 8;

    logic          addr_cmd, data_cmd, rd_req;
    logic          wr_en, rd_fire;
    logic [AW-1:0] ofs;
    logic [7:0]    wr_val, file_data, rd_val;
    logic [NEVT-1:0] en_q, stat_q, stat_clr;
    logic          en_wr;
    logic [7:0]    rdata_d, rdata_q;

    cmdport_decode #(.CMD_SEL(CMD_SEL)) u_dec (
        .fifo_addr(fifo_addr), .wr_strobe(wr_strobe), .rd_strobe(rd_strobe),
        .mark_bit(wdata[7]), .addr_cmd(addr_cmd), .data_cmd(data_cmd),
        .rd_req(rd_req));

    cmdport_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .addr_cmd(addr_cmd), .data_cmd(data_cmd),
        .rd_req(rd_req), .wdata(wdata), .wr_en(wr_en), .ofs(ofs),
        .wr_val(wr_val), .rd_fire(rd_fire), .ready(ready));

    cmdport_regs #(.AW(AW), .CFG_OFS(AW'(CFG_OFS)), .CFG_RST(CFG_RST),
                   .EN_OFS(AW'(EN_OFS)), .STAT_OFS(AW'(STAT_OFS))) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ofs(ofs),
        .wr_val(wr_val), .rd_ofs(ofs), .rd_data(file_data));

    cmdport_irq #(.NEVT(NEVT)) u_irq (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .en_wr(en_wr),
        .en_val(wr_val), .stat_clr(stat_clr), .en_q(en_q),
        .stat_q(stat_q), .int_n(int_n));

    always_comb begin
        en_wr = wr_en && (ofs == AW'(EN_OFS));
        if (ofs == AW'(EN_OFS))        rd_val = en_q;
        else if (ofs == AW'(STAT_OFS)) rd_val = stat_q;
        else                           rd_val = file_data;
        stat_clr = (rd_fire && ofs == AW'(STAT_OFS)) ? stat_q : '0;
        rdata_d  = rd_fire ? rd_val : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> $stable(rdata_q));
    // R1
    foreign_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_addr != CMD_SEL && ready) |=> ready);
endmodule

// File: tb/cmdport_test.sv
module cmdport_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] fifo_addr = 3'd0;
    logic       wr_strobe = 1'b0, rd_strobe = 1'b0;
    logic [7:0] wdata = 8'h00, evt_i = 8'h00;
    logic [7:0] rdata;
    logic       ready, int_n;

    int n_tests = 0, n_fail = 0;
    localparam logic [2:0] SEL = 3'd4;

    always #10 clk = ~clk;

    cmdport uut (.clk(clk), .rst_n(rst_n), .fifo_addr(fifo_addr),
        .wr_strobe(wr_strobe), .rd_strobe(rd_strobe), .wdata(wdata),
        .evt_i(evt_i), .rdata(rdata), .ready(ready), .int_n(int_n));

    // behavioural reference model
    int         m_st;      // 0 idle, 1 want upper, 2 want lower, 3 read pending
    logic [7:0] m_mem [64];
    logic [5:0] m_ofs;
    logic [3:0] m_hi;
    logic [7:0] m_en, m_stat, m_rd;

    function automatic logic [7:0] m_read(input logic [5:0] o);
        if (o == 6'h2E) return m_en;
        if (o == 6'h2F) return m_stat;
        return m_mem[o];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_ofs = '0; m_hi = '0; m_en = 8'hFF; m_stat = '0; m_rd = '0;
            for (int i = 0; i < 64; i++) m_mem[i] = 8'h00;
            m_mem[1] = 8'hC0;
        end else begin
            logic [7:0] old_en, clr;
            old_en = m_en;
            clr = '0;
            if (wr_strobe && fifo_addr == SEL) begin
                if (wdata[7]) begin
                    m_ofs = wdata[5:0];
                    m_st = wdata[6] ? 3 : 1;
                end else if (m_st == 1) begin
                    m_hi = wdata[3:0]; m_st = 2;
                end else if (m_st == 2) begin
                    if (m_ofs == 6'h2E) m_en = {m_hi, wdata[3:0]};
                    else if (m_ofs != 6'h2F) m_mem[m_ofs] = {m_hi, wdata[3:0]};
                    m_st = 0;
                end
            end else if (rd_strobe && fifo_addr == SEL && m_st == 3) begin
                m_rd = m_read(m_ofs);
                if (m_ofs == 6'h2F) clr = m_stat;
                m_st = 0;
            end
            m_stat = (m_stat & ~clr) | (evt_i & old_en);
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) if (rst_n) begin
        chk("R2/R3 ready", {7'd0, ready}, {7'd0, m_st == 0});
        chk("R8 int_n", {7'd0, int_n}, {7'd0, ~|(m_stat & m_en)});
        chk("R5 rdata", rdata, m_rd);
    end

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        fifo_addr = a; wdata = d; wr_strobe = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0; fifo_addr = 3'd0;
    endtask

    task automatic bus_rd(input logic [2:0] a, input logic [7:0] ev);
        @(negedge clk);
        fifo_addr = a; rd_strobe = 1'b1; evt_i = ev;
        @(negedge clk);
        rd_strobe = 1'b0; fifo_addr = 3'd0; evt_i = 8'h00;
    endtask

    task automatic reg_wr(input logic [5:0] o, input logic [7:0] v);
        bus_wr(SEL, {2'b10, o});
        bus_wr(SEL, {4'h0, v[7:4]});
        bus_wr(SEL, {4'h0, v[3:0]});
    endtask

    task automatic reg_rd(input logic [5:0] o, input logic [7:0] exp, input string tag);
        bus_wr(SEL, {2'b11, o});
        bus_rd(SEL, 8'h00);
        chk(tag, rdata, exp);
    endtask

    task automatic pulse(input logic [7:0] ev);
        @(negedge clk); evt_i = ev;
        @(negedge clk); evt_i = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R6 ready at reset", {7'd0, ready}, 8'h01);
        chk("R6 int_n at reset", {7'd0, int_n}, 8'h01);
        rst_n = 1'b1;
        reg_rd(6'h01, 8'hC0, "R6 config reset");
        reg_rd(6'h2E, 8'hFF, "R6 enable reset");
        reg_rd(6'h2F, 8'h00, "R6 status reset");
        reg_rd(6'h05, 8'h00, "R6 plain reset");

        reg_wr(6'h05, 8'hA5);
        reg_rd(6'h05, 8'hA5, "R3 write/read");
        reg_wr(6'h3F, 8'h3C);
        reg_rd(6'h3F, 8'h3C, "R3 top offset");

        // R4: abort after upper nibble
        bus_wr(SEL, 8'h85);
        bus_wr(SEL, 8'h0F);
        chk("R3 pending after upper", {7'd0, ready}, 8'h00);
        bus_wr(SEL, 8'h86);
        bus_wr(SEL, 8'h07);
        bus_wr(SEL, 8'h0E);
        reg_rd(6'h05, 8'hA5, "R4 aborted unchanged");
        reg_rd(6'h06, 8'h7E, "R4 restarted write");

        // R1: foreign address ignored
        bus_wr(3'd2, 8'h85);
        chk("R1 foreign addr ready", {7'd0, ready}, 8'h01);
        bus_wr(3'd2, 8'h01);
        bus_wr(3'd2, 8'h02);
        reg_rd(6'h05, 8'hA5, "R1 foreign no write");

        // R5: stray strobes ignored
        bus_wr(SEL, 8'h03);
        bus_rd(SEL, 8'h00);
        chk("R5 stray read holds", rdata, 8'hA5);

        // R7/R8/R9: endpoint-0 event on bit 6
        pulse(8'h40);
        @(negedge clk);
        chk("R8 int asserted", {7'd0, int_n}, 8'h00);
        reg_rd(6'h2F, 8'h40, "R7 status bit6");
        @(negedge clk);
        chk("R9 int released", {7'd0, int_n}, 8'h01);
        reg_rd(6'h2F, 8'h00, "R9 cleared");

        // R7: disabled event not recorded
        reg_wr(6'h2E, 8'hBF);
        pulse(8'h40);
        reg_rd(6'h2F, 8'h00, "R7 disabled event");

        // R8: masking without clearing
        pulse(8'h01);
        chk("R8 int low bit0", {7'd0, int_n}, 8'h00);
        reg_wr(6'h2E, 8'hBE);
        chk("R8 masked releases", {7'd0, int_n}, 8'h01);
        reg_wr(6'h2E, 8'hFF);
        chk("R8 unmask reasserts", {7'd0, int_n}, 8'h00);

        // R10: status not writable
        reg_wr(6'h2F, 8'hFF);
        reg_rd(6'h2F, 8'h01, "R10 status write ignored");

        // R9: event colliding with status read survives
        pulse(8'h04);
        bus_wr(SEL, 8'hEF);
        bus_rd(SEL, 8'h02);
        chk("R9 read value", rdata, 8'h04);
        reg_rd(6'h2F, 8'h02, "R9 collided event kept");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule